// File: doc/BRIEF.md
# TLB Entry Permission Checker

This block takes one TLB entry that a separate lookup stage has already matched, together with the virtual address of the access, the kind of access (instruction fetch, data load or data store) and the privilege level the core is running at. Each entry describes two neighbouring pages. The block works out the page size for the entry, uses one address bit to pick the even or the odd page, and runs the access-rights checks one after another in a fixed priority. It returns a 3-bit result code. When the access is allowed it also returns the physical address and the read, write and execute permissions of the page.

Two operating widths are supported. In 64-bit mode each page half carries a no-execute bit, a no-read bit and a restricted-privilege bit. In 32-bit mode those three bits are ignored. The page size comes from the entry itself when the entry sits in the fully associative part of the TLB. For the set-associative part it comes from one shared page-size value. The logic is combinational. An optional output register, chosen by a parameter, captures the result when an input-valid strobe is high.

Top module: `tlb_perm_check`

## Requirements
- R1: The page size used is `entry_ps` when `entry_idx >= FA_BASE` (default 2048), and `global_ps` when `entry_idx` is below it.
- R2: With page size PS, `vaddr[PS]` = 1 selects `half_odd` and 0 selects `half_even`. Each half word is laid out as bit 0 valid, bit 1 dirty, bits 3:2 page privilege level, bit 4 no-execute, bit 5 no-read, bit 6 restricted-privilege, bits 42:7 page frame number (PFN).
- R3: When `mode64` = 0, the no-execute, no-read and restricted-privilege bits of the selected half are treated as 0.
- R4: Result codes are 0 match, 1 invalid, 2 execute-inhibit, 3 read-inhibit, 4 privilege error, 5 dirty fault. The access kind is encoded as 0 fetch, 1 load, 2 store. The first test that fires sets the code, in this order: invalid (valid bit clear), fetch from a no-execute page, load from a no-read page, privilege violation, store to a page whose dirty bit is clear.
- R5: When restricted-privilege is 0, a privilege violation occurs if `cur_plv` is greater than the page level. When it is 1, a violation occurs if `cur_plv` differs from the page level.
- R6: A page size below 12 or above 30 gives result 1 (invalid), whatever the entry holds.
- R7: On a match, `paddr` = ((PFN with its bits below PS-12 cleared) << 12) | `vaddr[PS-1:0]`.
- R8: On a match, `perm_r` = 1, `perm_w` = dirty bit and `perm_x` = not no-execute. On any other result, `paddr` and all three permissions are 0.
- R9: With REG_OUT = 1, `out_valid` follows `in_valid` one clock later and the outputs show the result of the inputs present at that edge. When `in_valid` = 0 the data outputs hold their values. Reset clears `out_valid`, `result`, `paddr` and the permissions to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Inputs carry an access to check; enables the capture |
| entry_idx | input | 12 | TLB slot of the matched entry |
| entry_ps | input | 5 | Page size stored in the entry |
| global_ps | input | 5 | Shared page size for the set-associative slots |
| vaddr | input | 48 | Virtual address of the access |
| acc_kind | input | 2 | 0 fetch, 1 load, 2 store |
| cur_plv | input | 2 | Current privilege level |
| mode64 | input | 1 | 1 = 64-bit mode, 0 = 32-bit mode |
| half_even | input | 43 | Even page half of the entry |
| half_odd | input | 43 | Odd page half of the entry |
| out_valid | output | 1 | Result is valid |
| result | output | 3 | Result code |
| paddr | output | 48 | Physical address on a match |
| perm_r | output | 1 | Read allowed |
| perm_w | output | 1 | Write allowed |
| perm_x | output | 1 | Execute allowed |

## Verification
The assertions assume that `acc_kind` never takes the unused value 3 and that `vaddr` is wider than the largest selectable page-size bit, so that `vaddr[PS]` always exists. The offset check also assumes that the inputs are settled while reset is inactive. The bench only ever drives access kinds 0 to 2. Its page sizes cover the legal edges 12 and 30 and the illegal values 11 and 31, and all 5-bit page sizes fit inside the 48-bit address. The inputs change only on the falling clock edge, so every sampled value is stable when the output register captures it.

// File: rtl/tpc_pkg.sv
package tpc_pkg;

  localparam int PLV_W    = 2;
  localparam int PAGE_OFF = 12;
  localparam int PS_MIN   = 12;
  localparam int PS_MAX   = 30;

  // bit positions inside one page-half word
  localparam int HB_VALID = 0;
  localparam int HB_DIRTY = 1;
  localparam int HB_PLV   = 2;
  localparam int HB_NOEX  = 4;
  localparam int HB_NORD  = 5;
  localparam int HB_RPRV  = 6;
  localparam int HB_PFN   = 7;

  typedef enum logic [2:0] {
    RES_MATCH   = 3'd0,
    RES_INVALID = 3'd1,
    RES_XINH    = 3'd2,
    RES_RINH    = 3'd3,
    RES_PRIV    = 3'd4,
    RES_DIRTY   = 3'd5
  } tpc_res_e;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2
  } tpc_acc_e;

  typedef struct packed {
    logic             valid;
    logic             dirty;
    logic [PLV_W-1:0] plv;
    logic             noex;
    logic             nord;
    logic             rprv;
  } tpc_flags_t;

endpackage

// File: rtl/tpc_page_sel.sv
module tpc_page_sel
  import tpc_pkg::*;
#(
  parameter int VA_W    = 48,
  parameter int PFN_W   = 36,
  parameter int PS_W    = 5,
  parameter int IDX_W   = 12,
  parameter int FA_BASE = 2048,
  localparam int HALF_W = HB_PFN + PFN_W
) (
  input  logic [IDX_W-1:0]  entry_idx,
  input  logic [PS_W-1:0]   entry_ps,
  input  logic [PS_W-1:0]   global_ps,
  input  logic [VA_W-1:0]   vaddr,
  input  logic              mode64,
  input  logic [HALF_W-1:0] half_even,
  input  logic [HALF_W-1:0] half_odd,
  output logic [PS_W-1:0]   ps,
  output logic              ps_ok,
  output tpc_flags_t        flags,
  output logic [PFN_W-1:0]  pfn
);

  logic              use_own;
  logic              odd_sel;
  logic [HALF_W-1:0] half;

  always_comb begin
    use_own = (int'(entry_idx) >= FA_BASE);
    ps      = use_own ? entry_ps : global_ps;
    ps_ok   = (int'(ps) >= PS_MIN) && (int'(ps) <= PS_MAX);
  end

  always_comb begin
    odd_sel = vaddr[ps];
    half    = odd_sel ? half_odd : half_even;
  end

  // 32-bit mode strips the extended protection bits
  always_comb begin
    flags.valid = half[HB_VALID];
    flags.dirty = half[HB_DIRTY];
    flags.plv   = half[HB_PLV +: PLV_W];
    flags.noex  = half[HB_NOEX] & mode64;
    flags.nord  = half[HB_NORD] & mode64;
    flags.rprv  = half[HB_RPRV] & mode64;
    pfn         = half[HB_PFN +: PFN_W];
  end

endmodule

// File: rtl/tpc_rights.sv
module tpc_rights
  import tpc_pkg::*;
(
  input  logic             rst_n,
  input  logic             ps_ok,
  input  tpc_flags_t       flags,
  input  logic [1:0]       acc_kind,
  input  logic [PLV_W-1:0] cur_plv,
  output tpc_res_e         res
);

  logic priv_fault;

  always_comb begin
    if (flags.rprv) priv_fault = (cur_plv != flags.plv);
    else            priv_fault = (cur_plv >  flags.plv);
  end

  always_comb begin
    if (!ps_ok || !flags.valid)                        res = RES_INVALID;
    else if ((acc_kind == ACC_FETCH) && flags.noex)    res = RES_XINH;
    else if ((acc_kind == ACC_LOAD) && flags.nord)     res = RES_RINH;
    else if (priv_fault)                               res = RES_PRIV;
    else if ((acc_kind == ACC_STORE) && !flags.dirty)  res = RES_DIRTY;
    else                                               res = RES_MATCH;
  end

  always_comb begin
    if (rst_n) begin
      AST_BADPS_INVALID: assert (ps_ok || (res == RES_INVALID))
        else $error("illegal page size not flagged invalid"); // R6
      AST_STORE_CLEAN: assert (!((acc_kind == ACC_STORE) && !flags.dirty) || (res != RES_MATCH))
        else $error("store to clean page matched"); // R4
    end
  end

endmodule

// File: rtl/tpc_pa_form.sv
module tpc_pa_form
  import tpc_pkg::*;
#(
  parameter int VA_W  = 48,
  parameter int PFN_W = 36,
  parameter int PS_W  = 5,
  localparam int PA_W = PFN_W + PAGE_OFF
) (
  input  logic             rst_n,
  input  logic [PS_W-1:0]  ps,
  input  logic [PFN_W-1:0] pfn,
  input  logic [VA_W-1:0]  vaddr,
  input  logic             match,
  input  logic             dirty,
  input  logic             noex,
  output logic [PA_W-1:0]  paddr,
  output logic             perm_r,
  output logic             perm_w,
  output logic             perm_x
);

  logic [PFN_W-1:0] pfn_keep;
  logic [PA_W-1:0]  off_bits;
  logic [PA_W-1:0]  pa_raw;

  // PFN bits that overlap the page offset belong to software
  for (genvar j = 0; j < PFN_W; j++) begin : g_pfn
    assign pfn_keep[j] = pfn[j] & ((j + PAGE_OFF) >= int'(ps));
  end

  for (genvar i = 0; i < PA_W; i++) begin : g_off
    if (i < VA_W) begin : g_va
      assign off_bits[i] = vaddr[i] & (i < int'(ps));
    end else begin : g_zero
      assign off_bits[i] = 1'b0;
    end
  end

  always_comb begin
    pa_raw = {pfn_keep, {PAGE_OFF{1'b0}}} | off_bits;
    paddr  = match ? pa_raw : '0;
    perm_r = match;
    perm_w = match & dirty;
    perm_x = match & ~noex;
  end

  always_comb begin
    if (rst_n && match) begin
      AST_PA_OFFSET: assert (((paddr ^ PA_W'(vaddr)) & ((PA_W'(1) << ps) - PA_W'(1))) == '0)
        else $error("page offset not carried into physical address"); // R7
    end
  end

endmodule

// File: rtl/tlb_perm_check.sv
module tlb_perm_check
  import tpc_pkg::*;
#(
  parameter int VA_W    = 48,
  parameter int PFN_W   = 36,
  parameter int PS_W    = 5,
  parameter int IDX_W   = 12,
  parameter int FA_BASE = 2048,
  parameter bit REG_OUT = 1'b1,
  localparam int PA_W   = PFN_W + PAGE_OFF,
  localparam int HALF_W = HB_PFN + PFN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [IDX_W-1:0]  entry_idx,
  input  logic [PS_W-1:0]   entry_ps,
  input  logic [PS_W-1:0]   global_ps,
  input  logic [VA_W-1:0]   vaddr,
  input  logic [1:0]        acc_kind,
  input  logic [PLV_W-1:0]  cur_plv,
  input  logic              mode64,
  input  logic [HALF_W-1:0] half_even,
  input  logic [HALF_W-1:0] half_odd,
  output logic              out_valid,
  output logic [2:0]        result,
  output logic [PA_W-1:0]   paddr,
  output logic              perm_r,
  output logic              perm_w,
  output logic              perm_x
);

  logic [PS_W-1:0]  sel_ps;
  logic             sel_ps_ok;
  tpc_flags_t       sel_flags;
  logic [PFN_W-1:0] sel_pfn;
  tpc_res_e         chk_res;
  logic [PA_W-1:0]  c_paddr;
  logic             c_r, c_w, c_x;

  tpc_page_sel #(
    .VA_W(VA_W), .PFN_W(PFN_W), .PS_W(PS_W), .IDX_W(IDX_W), .FA_BASE(FA_BASE)
  ) u_sel (
    .entry_idx(entry_idx), .entry_ps(entry_ps), .global_ps(global_ps),
    .vaddr(vaddr), .mode64(mode64), .half_even(half_even), .half_odd(half_odd),
    .ps(sel_ps), .ps_ok(sel_ps_ok), .flags(sel_flags), .pfn(sel_pfn)
  );

  tpc_rights u_rights (
    .rst_n(rst_n), .ps_ok(sel_ps_ok), .flags(sel_flags),
    .acc_kind(acc_kind), .cur_plv(cur_plv), .res(chk_res)
  );

  tpc_pa_form #(
    .VA_W(VA_W), .PFN_W(PFN_W), .PS_W(PS_W)
  ) u_pa (
    .rst_n(rst_n), .ps(sel_ps), .pfn(sel_pfn), .vaddr(vaddr),
    .match(chk_res == RES_MATCH), .dirty(sel_flags.dirty), .noex(sel_flags.noex),
    .paddr(c_paddr), .perm_r(c_r), .perm_w(c_w), .perm_x(c_x)
  );

  if (REG_OUT) begin : g_reg
    logic            vld_q, vld_d;
    logic [2:0]      res_q, res_d;
    logic [PA_W-1:0] pa_q, pa_d;
    logic [2:0]      prm_q, prm_d;

    // next state: data captured only when in_valid enables it
    always_comb begin
      vld_d = in_valid;
      res_d = res_q;
      pa_d  = pa_q;
      prm_d = prm_q;
      if (in_valid) begin
        res_d = chk_res;
        pa_d  = c_paddr;
        prm_d = {c_r, c_w, c_x};
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
        res_q <= '0;
        pa_q  <= '0;
        prm_q <= '0;
      end else begin
        vld_q <= vld_d;
        res_q <= res_d;
        pa_q  <= pa_d;
        prm_q <= prm_d;
      end
    end

    assign out_valid = vld_q;
    assign result    = res_q;
    assign paddr     = pa_q;
    assign {perm_r, perm_w, perm_x} = prm_q;

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid) else $error("out_valid missed"); // R9
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(result) && $stable(paddr) && $stable(perm_w)))
      else $error("outputs changed without in_valid"); // R9
  end else begin : g_comb
    assign out_valid = in_valid;
    assign result    = chk_res;
    assign paddr     = c_paddr;
    assign {perm_r, perm_w, perm_x} = {c_r, c_w, c_x};
  end

  AST_FAULT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (result != 3'd0)) |-> ((paddr == '0) && !perm_r && !perm_w && !perm_x))
    else $error("fault result leaks address or permissions"); // R8
  AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (result <= 3'd5)) else $error("result code out of range"); // R4

endmodule

// File: tb/tlb_perm_check_test.sv
module tlb_perm_check_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [11:0] entry_idx;
  logic [4:0]  entry_ps, global_ps;
  logic [47:0] vaddr;
  logic [1:0]  acc_kind, cur_plv;
  logic        mode64;
  logic [42:0] half_even, half_odd;
  logic        out_valid;
  logic [2:0]  result;
  logic [47:0] paddr;
  logic        perm_r, perm_w, perm_x;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tlb_perm_check uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .entry_idx(entry_idx),
    .entry_ps(entry_ps), .global_ps(global_ps), .vaddr(vaddr), .acc_kind(acc_kind),
    .cur_plv(cur_plv), .mode64(mode64), .half_even(half_even), .half_odd(half_odd),
    .out_valid(out_valid), .result(result), .paddr(paddr),
    .perm_r(perm_r), .perm_w(perm_w), .perm_x(perm_x)
  );

  function automatic logic [42:0] mk_half(bit v, bit d, logic [1:0] plv, bit nx,
                                          bit nr, bit rp, logic [35:0] pfn);
    return {pfn, rp, nr, nx, plv, d, v};
  endfunction

  // expected values written from the requirement text
  logic [2:0]  e_res;
  logic [47:0] e_pa;
  logic        e_r, e_w, e_x;

  task automatic ref_eval();
    int ps;
    logic [42:0] h;
    bit nx, nr, rp;
    logic [35:0] pfn;
    ps  = (entry_idx >= 12'd2048) ? int'(entry_ps) : int'(global_ps);
    h   = vaddr[ps] ? half_odd : half_even;
    nx  = h[4] & mode64;
    nr  = h[5] & mode64;
    rp  = h[6] & mode64;
    pfn = h[42:7];
    if (ps < 12 || ps > 30)                       e_res = 3'd1;
    else if (!h[0])                               e_res = 3'd1;
    else if (acc_kind == 2'd0 && nx)              e_res = 3'd2;
    else if (acc_kind == 2'd1 && nr)              e_res = 3'd3;
    else if (rp ? (cur_plv != h[3:2]) : (cur_plv > h[3:2])) e_res = 3'd4;
    else if (acc_kind == 2'd2 && !h[1])           e_res = 3'd5;
    else                                          e_res = 3'd0;
    if (e_res == 3'd0) begin
      for (int j = 0; j < 36; j++) if (j + 12 < ps) pfn[j] = 1'b0;
      e_pa = ({12'h0, pfn} << 12) | (vaddr & ((48'd1 << ps) - 48'd1));
      e_r = 1'b1; e_w = h[1]; e_x = ~nx;
    end else begin
      e_pa = '0; e_r = 1'b0; e_w = 1'b0; e_x = 1'b0;
    end
  endtask

  task automatic chk(string req, string what, logic [47:0] act, logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // drive on a falling edge, capture on the rising edge, sample on the next falling edge
  task automatic run(string req, int exp_code);
    @(negedge clk);
    in_valid = 1'b1;
    ref_eval();
    @(negedge clk);
    in_valid = 1'b0;
    chk(req, "out_valid", 48'(out_valid), 48'd1);
    chk(req, "result", 48'(result), 48'(exp_code));
    chk(req, "result_ref", 48'(result), 48'(e_res));
    chk(req, "paddr", paddr, e_pa);
    chk(req, "perms", 48'({perm_r, perm_w, perm_x}), 48'({e_r, e_w, e_x}));
  endtask

  task automatic defaults();
    entry_idx = 12'd5; entry_ps = 5'd14; global_ps = 5'd14;
    vaddr = 48'h0; acc_kind = 2'd1; cur_plv = 2'd0; mode64 = 1'b1;
    half_even = mk_half(1, 1, 2'd0, 0, 0, 0, 36'h0_0000_1111);
    half_odd  = mk_half(1, 1, 2'd0, 0, 0, 0, 36'h0_0000_2222);
  endtask

  task automatic t_reset();
    chk("R9", "reset out_valid", 48'(out_valid), 48'd0);
    chk("R9", "reset result", 48'(result), 48'd0);
    chk("R9", "reset paddr", paddr, 48'd0);
    chk("R9", "reset perms", 48'({perm_r, perm_w, perm_x}), 48'd0);
  endtask

  task automatic t_ps_source();   // R1
    defaults();
    half_even = mk_half(0, 1, 2'd3, 0, 0, 0, 36'h0_0000_1000);
    half_odd  = mk_half(1, 1, 2'd3, 0, 0, 0, 36'h0_0000_2000);
    global_ps = 5'd14; entry_ps = 5'd21;
    vaddr = 48'h0000_0000_4000;          // bit 14 set, bit 21 clear
    entry_idx = 12'd100;  run("R1", 0);  // global size -> odd half
    entry_idx = 12'd2047; run("R1", 0);
    entry_idx = 12'd2048; run("R1", 1);  // own size -> even, invalid
    entry_idx = 12'd3000; run("R1", 1);
  endtask

  task automatic t_half();        // R2
    defaults();
    half_even = mk_half(1, 0, 2'd0, 0, 0, 0, 36'h0_0000_0ABC);
    half_odd  = mk_half(1, 1, 2'd0, 0, 0, 0, 36'h0_0000_0DEF);
    acc_kind = 2'd2;
    vaddr = 48'h0000_0000_0123; run("R2", 5);
    vaddr = 48'h0000_0000_4123; run("R2", 0);
    chk("R2", "odd pfn", paddr, 48'h0000_00DE_C123);
  endtask

  task automatic t_mode32();      // R3
    defaults();
    half_even = mk_half(1, 1, 2'd3, 1, 1, 1, 36'h0_0000_0040);
    cur_plv = 2'd0;
    mode64 = 1'b0; acc_kind = 2'd0; run("R3", 0);
    chk("R3", "exec granted", 48'(perm_x), 48'd1);
    mode64 = 1'b1; acc_kind = 2'd0; run("R3", 2);
    mode64 = 1'b0; acc_kind = 2'd1; run("R3", 0);
    mode64 = 1'b1; acc_kind = 2'd1; run("R3", 3);
    half_even = mk_half(1, 1, 2'd3, 0, 0, 1, 36'h0_0000_0040);
    mode64 = 1'b0; run("R3", 0);
    mode64 = 1'b1; run("R3", 4);
  endtask

  task automatic t_priority();    // R4
    defaults();
    cur_plv = 2'd3;
    half_even = mk_half(0, 0, 2'd0, 1, 1, 0, 36'h5); acc_kind = 2'd0; run("R4", 1);
    half_even = mk_half(1, 0, 2'd0, 1, 1, 0, 36'h5); acc_kind = 2'd0; run("R4", 2);
    acc_kind = 2'd1; run("R4", 3);
    acc_kind = 2'd2; run("R4", 4);
    cur_plv = 2'd0; run("R4", 5);
    half_even = mk_half(1, 1, 2'd0, 1, 1, 0, 36'h5); run("R4", 0);
  endtask

  task automatic t_priv();        // R5
    defaults();
    half_even = mk_half(1, 1, 2'd1, 0, 0, 0, 36'h7);
    cur_plv = 2'd0; run("R5", 0);
    cur_plv = 2'd1; run("R5", 0);
    cur_plv = 2'd2; run("R5", 4);
    half_even = mk_half(1, 1, 2'd1, 0, 0, 1, 36'h7);
    cur_plv = 2'd0; run("R5", 4);
    cur_plv = 2'd1; run("R5", 0);
    cur_plv = 2'd3; run("R5", 4);
  endtask

  task automatic t_bad_ps();      // R6
    defaults();
    vaddr = 48'h0;
    global_ps = 5'd11; run("R6", 1);
    global_ps = 5'd12; run("R6", 0);
    global_ps = 5'd30; run("R6", 0);
    global_ps = 5'd31; run("R6", 1);
    entry_idx = 12'd2500; entry_ps = 5'd31; global_ps = 5'd14; run("R6", 1);
  endtask

  task automatic t_pa();          // R7
    defaults();
    global_ps = 5'd12;
    half_even = mk_half(1, 1, 2'd0, 0, 0, 0, 36'h0_0001_2345);
    vaddr = 48'h0000_0000_0ABC; run("R7", 0);
    chk("R7", "ps12 paddr", paddr, 48'h0000_1234_5ABC);
    global_ps = 5'd16;
    half_even = mk_half(1, 1, 2'd0, 0, 0, 0, 36'h0_0001_234F);
    vaddr = 48'h0000_0000_7ABC; run("R7", 0);
    chk("R7", "ps16 paddr", paddr, 48'h0000_1234_7ABC);
    global_ps = 5'd30;
    half_even = mk_half(1, 1, 2'd0, 0, 0, 0, 36'h0_000F_FFFF);
    vaddr = 48'h0000_1234_5678; run("R7", 0);
    chk("R7", "ps30 paddr", paddr, 48'h0000_C000_0000 | 48'h0000_1234_5678 & 48'h3FFF_FFFF);
  endtask

  task automatic t_perms();       // R8
    defaults();
    half_even = mk_half(1, 0, 2'd0, 0, 0, 0, 36'h9);
    acc_kind = 2'd1; run("R8", 0);
    chk("R8", "rwx clean", 48'({perm_r, perm_w, perm_x}), 48'b101);
    half_even = mk_half(1, 1, 2'd0, 1, 0, 0, 36'h9);
    run("R8", 0);
    chk("R8", "rwx noexec", 48'({perm_r, perm_w, perm_x}), 48'b110);
    half_even = mk_half(0, 1, 2'd0, 0, 0, 0, 36'h9);
    run("R8", 1);
    chk("R8", "fault paddr", paddr, 48'h0);
  endtask

  task automatic t_hold();        // R9
    logic [2:0]  r0;
    logic [47:0] p0;
    defaults();
    half_even = mk_half(1, 1, 2'd0, 0, 0, 0, 36'h33);
    run("R9", 0);
    r0 = result; p0 = paddr;
    @(negedge clk);
    half_even = mk_half(0, 0, 2'd0, 0, 0, 0, 36'h44);
    @(negedge clk);
    chk("R9", "idle out_valid", 48'(out_valid), 48'd0);
    chk("R9", "idle result held", 48'(result), 48'(r0));
    chk("R9", "idle paddr held", paddr, p0);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0;
    defaults();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_ps_source();
    t_half();
    t_mode32();
    t_priority();
    t_priv();
    t_bad_ps();
    t_pa();
    t_perms();
    t_hold();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule